// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a self-test of a small synchronous single-port RAM. After a start pulse it takes sole control of the RAM's enable, write-enable, address and write-data lines and runs a fixed suite of six test patterns. The suite covers solid backgrounds, walking patterns and galloping patterns. Read data is not compared word by word. Every word read back is folded into a multiple-input signature register, and at the end the signature is compared against a golden value that is fixed when the block is instantiated.

The RAM is expected to return read data one cycle after the read is issued. The block needs no configuration. An integrator fixes the depth, the word width, the feedback polynomial and the golden signature through parameters. The integrator then pulses `start`, waits for `done`, and samples `pass` or the raw `signature`.

Top module: `mbist_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `pass`, `ram_en` and `ram_we` are 0 and `signature` is all zeros.
- R2: `start` is accepted only while the block is idle. A `start` pulse during a run does not change the access sequence, the run length or the final signature.
- R3: An accepted `start` clears `signature` to zero at that same edge. Each read is folded in one cycle after it is issued, as s' = (s shifted left by one) XOR (POLY if the old MSB was 1, else 0) XOR rdata.
- R4: The six patterns run in this order: solid-0, solid-1, walking-1, walking-0, galloping-1, galloping-0. The background word is all zeros for the 1st, 3rd and 5th patterns and all ones for the others. Every written word is either all zeros or all ones.
- R5: A solid pattern writes the background to addresses 0 to DEPTH-1 in ascending order, then reads them back in the same order.
- R6: A walking pattern first fills memory with the background. Then, for each base address in ascending order, it writes the complement to the base, reads every address in ascending order, and writes the background back to the base.
- R7: A galloping pattern first fills memory with the background. Then, for each base address in ascending order, it writes the complement to the base. For every other address in ascending order it reads that address and then reads the base. Finally it restores the base to the background.
- R8: A run issues exactly 14·DEPTH writes and 2·DEPTH + 2·DEPTH² + 4·DEPTH·(DEPTH−1) reads on consecutive cycles. For DEPTH=16 that is 1728 accesses. `done` rises in the cycle after the last access, 1728 clock edges after the edge that accepted `start`.
- R9: `done` is high for exactly one cycle. `ram_en` is low whenever the block is idle.
- R10: `pass` is 1 exactly when `signature` equals GOLDEN. It is first valid in the `done` cycle and holds until the next accepted `start`, which drops it at that edge.
- R11: A RAM bit stuck at a fixed value yields the signature of the faulty read stream, and `pass` reflects its comparison with GOLDEN.
- R12: `ram_addr` stays below DEPTH whenever `ram_en` is high, and `ram_we` is never high without `ram_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test run (honoured only when idle) |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_addr | output | AW = clog2(DEPTH) | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after a read |
| done | output | 1 | One-cycle end-of-run pulse |
| signature | output | DW | Compressed read-data signature |
| pass | output | 1 | Signature matched GOLDEN on the last run |

## Verification
The bench drives a behavioural RAM and records every access. It compares the trace against an expected sequence built pattern by pattern, so a wrong order, address skip or background shows up in the region of the solid, walking or galloping pattern concerned. A fault-free run separates a correct data path from a broken compressor through the exact golden signature. A second start pulse injected mid-run checks that a busy sequencer ignores it. A run against a RAM with one bit stuck at 1 has to land on the signature the bench predicts for that faulty read stream. A repeated run shows the signature being cleared and `pass` dropping at the new start.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  // Sequencer micro-states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,    // write background to j
    ST_SCAN,    // read j
    ST_MARK,    // write complement to base
    ST_PEER,    // galloping: read other cell j
    ST_BASE,    // galloping: re-read base
    ST_UNMARK,  // restore background at base
    ST_FINISH
  } seq_state_e;

  // Pattern suite, in run order
  typedef enum logic [2:0] {
    PAT_SOLID0,
    PAT_SOLID1,
    PAT_WALK1,
    PAT_WALK0,
    PAT_GAL1,
    PAT_GAL0
  } pat_e;

  // Background bit of a pattern: odd entries use all ones
  function automatic logic pat_background(pat_e p);
    return p[0];
  endfunction

  function automatic logic pat_is_solid(pat_e p);
    return (p == PAT_SOLID0) || (p == PAT_SOLID1);
  endfunction

  function automatic logic pat_is_walk(pat_e p);
    return (p == PAT_WALK1) || (p == PAT_WALK0);
  endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          start_acc,
  output logic          busy,
  output logic          finish,
  output logic          op_en,
  output logic          op_we,
  output logic [AW-1:0] op_addr,
  output logic          op_val
);
  import mbist_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  seq_state_e    st_q, st_d;
  pat_e          pat_q, pat_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] idx_q, idx_d;

  // First peer address visited for a galloping base
  function automatic logic [AW-1:0] first_peer(logic [AW-1:0] b);
    return (b == '0) ? AW'(1) : '0;
  endfunction

  // Final peer address visited for a galloping base
  function automatic logic [AW-1:0] last_peer(logic [AW-1:0] b);
    return (b == LAST) ? (LAST - AW'(1)) : LAST;
  endfunction

  // Next peer, skipping the base itself
  function automatic logic [AW-1:0] step_peer(logic [AW-1:0] j, logic [AW-1:0] b);
    return ((j + AW'(1)) == b) ? (j + AW'(2)) : (j + AW'(1));
  endfunction

  always_comb begin
    st_d   = st_q;
    pat_d  = pat_q;
    base_d = base_q;
    idx_d  = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_FILL;
          pat_d  = PAT_SOLID0;
          base_d = '0;
          idx_d  = '0;
        end
      end
      ST_FILL: begin
        if (idx_q == LAST) begin
          idx_d  = '0;
          base_d = '0;
          st_d   = pat_is_solid(pat_q) ? ST_SCAN : ST_MARK;
        end else begin
          idx_d = idx_q + AW'(1);
        end
      end
      ST_SCAN: begin
        if (idx_q == LAST) begin
          idx_d = '0;
          if (pat_is_solid(pat_q)) begin
            st_d = ST_FILL;
            pat_d = pat_e'(pat_q + 3'd1);
          end else begin
            st_d = ST_UNMARK;
          end
        end else begin
          idx_d = idx_q + AW'(1);
        end
      end
      ST_MARK: begin
        if (pat_is_walk(pat_q)) begin
          st_d  = ST_SCAN;
          idx_d = '0;
        end else begin
          st_d  = ST_PEER;
          idx_d = first_peer(base_q);
        end
      end
      ST_PEER: st_d = ST_BASE;
      ST_BASE: begin
        if (idx_q == last_peer(base_q)) begin
          st_d = ST_UNMARK;
        end else begin
          st_d  = ST_PEER;
          idx_d = step_peer(idx_q, base_q);
        end
      end
      ST_UNMARK: begin
        if (base_q == LAST) begin
          base_d = '0;
          idx_d  = '0;
          if (pat_q == PAT_GAL0) begin
            st_d = ST_FINISH;
          end else begin
            st_d  = ST_FILL;
            pat_d = pat_e'(pat_q + 3'd1);
          end
        end else begin
          base_d = base_q + AW'(1);
          st_d   = ST_MARK;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pat_q  <= PAT_SOLID0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      pat_q  <= pat_d;
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

  logic on_base;
  assign on_base   = (st_q == ST_MARK) || (st_q == ST_BASE) || (st_q == ST_UNMARK);
  assign op_we     = (st_q == ST_FILL) || (st_q == ST_MARK) || (st_q == ST_UNMARK);
  assign op_en     = op_we || (st_q == ST_SCAN) || (st_q == ST_PEER) || (st_q == ST_BASE);
  assign op_addr   = on_base ? base_q : idx_q;
  assign op_val    = pat_background(pat_q) ^ (st_q == ST_MARK);
  assign busy      = (st_q != ST_IDLE);
  assign start_acc = (st_q == ST_IDLE) && start;
  assign finish    = (st_q == ST_FINISH);

endmodule

// File: rtl/mbist_misr.sv
module mbist_misr #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] POLY = DW'(29)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fold,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sig
);

  // One compression step: shift, reduce by POLY on carry-out, mix data
  function automatic logic [DW-1:0] misr_step(logic [DW-1:0] s, logic [DW-1:0] d);
    logic [DW-1:0] sh;
    sh = {s[DW-2:0], 1'b0};
    if (s[DW-1]) sh = sh ^ POLY;
    return sh ^ d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (fold)  sig <= misr_step(sig, din);
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int            DEPTH  = 16,
  parameter int            DW     = 8,
  parameter logic [DW-1:0] POLY   = DW'(29),
  parameter logic [DW-1:0] GOLDEN = '0,
  localparam int           AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          done,
  output logic [DW-1:0] signature,
  output logic          pass
);

  logic start_acc, busy, finish, op_val;
  logic rd_pend_q, verdict_q;

  mbist_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_acc (start_acc),
    .busy      (busy),
    .finish    (finish),
    .op_en     (ram_en),
    .op_we     (ram_we),
    .op_addr   (ram_addr),
    .op_val    (op_val)
  );

  assign ram_wdata = {DW{op_val}};

  // Read issued this cycle -> data arrives next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= ram_en && !ram_we;
  end

  mbist_misr #(.DW(DW), .POLY(POLY)) u_misr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_acc),
    .fold  (rd_pend_q),
    .din   (ram_rdata),
    .sig   (signature)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         verdict_q <= 1'b0;
    else if (start_acc) verdict_q <= 1'b0;
    else if (finish)    verdict_q <= 1'b1;
  end

  assign done = finish;
  assign pass = (finish || verdict_q) && (signature == GOLDEN);

endmodule

// File: rtl/mbist_ctrl_sva.sv
module mbist_ctrl_sva #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          done,
  input logic          pass,
  input logic [DW-1:0] signature,
  input logic          busy,
  input logic          rd_pend,
  input logic          sig_clear
);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_en);

  a_r12_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en);

  a_r12_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (int'(ram_addr) < DEPTH));

  a_r4_solid_words: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_wdata == '0) || (ram_wdata == '1)));

  a_r3_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pend && !sig_clear) |=> $stable(signature));

  a_r3_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clear |=> (signature == '0));

  a_r10_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> done);

  a_r2_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind mbist_ctrl mbist_ctrl_sva #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .done      (done),
  .pass      (pass),
  .signature (signature),
  .busy      (busy),
  .rd_pend   (rd_pend_q),
  .sig_clear (start_acc)
);

// File: tb/mbist_ctrl_tb_top.sv
module mbist_ctrl_tb_top;

  localparam int          N    = 16;
  localparam int          W    = 8;
  localparam int          AW   = $clog2(N);
  localparam logic [W-1:0] P   = W'(29);
  localparam int SOLID_OPS = 4 * N;
  localparam int WALK_OPS  = 2 * (N + N * (N + 2));
  localparam int GAL_OPS   = 2 * (N + 2 * N * N);
  localparam int NOPS      = SOLID_OPS + WALK_OPS + GAL_OPS;
  localparam int NWR       = 14 * N;

  // Signature restated: multiply by x modulo POLY, then add data
  function automatic logic [W-1:0] fold(logic [W-1:0] s, logic [W-1:0] d);
    logic [W-1:0] r;
    r = (s << 1) ^ ({W{s[W-1]}} & P);
    return r ^ d;
  endfunction

  function automatic logic [W-1:0] kept(int a, logic [W-1:0] v,
                                        bit flt, int fa, int fb, bit fv);
    logic [W-1:0] r;
    r = v;
    if (flt && a == fa) r[fb] = fv;
    return r;
  endfunction

  // Expected signature of a full run on a RAM with an optional stuck bit
  function automatic logic [W-1:0] ref_sig(bit flt, int fa, int fb, bit fv);
    logic [W-1:0] m [N];
    logic [W-1:0] s, bg;
    s = '0;
    for (int ph = 0; ph < 6; ph++) begin
      bg = (ph % 2 == 1) ? '1 : '0;
      for (int a = 0; a < N; a++) m[a] = kept(a, bg, flt, fa, fb, fv);
      if (ph < 2) begin
        for (int a = 0; a < N; a++) s = fold(s, m[a]);
      end else begin
        for (int b = 0; b < N; b++) begin
          m[b] = kept(b, ~bg, flt, fa, fb, fv);
          if (ph < 4) begin
            for (int a = 0; a < N; a++) s = fold(s, m[a]);
          end else begin
            for (int j = 0; j < N; j++) begin
              if (j != b) begin
                s = fold(s, m[j]);
                s = fold(s, m[b]);
              end
            end
          end
          m[b] = kept(b, bg, flt, fa, fb, fv);
        end
      end
    end
    return s;
  endfunction

  localparam logic [W-1:0] GOLD = ref_sig(1'b0, 0, 0, 1'b0);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ram_en, ram_we, done, pass;
  logic [AW-1:0] ram_addr;
  logic [W-1:0]  ram_wdata, ram_rdata, signature;

  always #10 clk = ~clk;

  mbist_ctrl #(.DEPTH(N), .DW(W), .POLY(P), .GOLDEN(GOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .signature(signature), .pass(pass)
  );

  // Behavioural RAM, one-cycle read, optional stuck-at bit
  logic [W-1:0] mem [N];
  bit flt_en = 0;
  int flt_addr = 0, flt_bit = 0;
  bit flt_val = 0;
  always @(posedge clk) begin
    if (ram_en && ram_we) mem[ram_addr] <= kept(int'(ram_addr), ram_wdata, flt_en, flt_addr, flt_bit, flt_val);
    if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
  end

  int nchk = 0, nerr = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected access trace
  logic          exp_we   [NOPS];
  logic [AW-1:0] exp_addr [NOPS];
  logic [W-1:0]  exp_wd   [NOPS];
  int k_fill;

  task automatic push(logic we, int a, logic [W-1:0] d);
    exp_we[k_fill] = we; exp_addr[k_fill] = AW'(a); exp_wd[k_fill] = d;
    k_fill++;
  endtask

  task automatic build_trace();
    logic [W-1:0] bg;
    k_fill = 0;
    for (int ph = 0; ph < 6; ph++) begin
      bg = (ph % 2 == 1) ? '1 : '0;
      for (int a = 0; a < N; a++) push(1'b1, a, bg);
      if (ph < 2) begin
        for (int a = 0; a < N; a++) push(1'b0, a, '0);
      end else begin
        for (int b = 0; b < N; b++) begin
          push(1'b1, b, ~bg);
          if (ph < 4) begin
            for (int a = 0; a < N; a++) push(1'b0, a, '0);
          end else begin
            for (int j = 0; j < N; j++)
              if (j != b) begin push(1'b0, j, '0); push(1'b0, b, '0); end
          end
          push(1'b1, b, bg);
        end
      end
    end
  endtask

  // Trace monitor, sampled mid-cycle
  bit mon_on = 0;
  int op_n, wr_n, rd_n, err_solid, err_walk, err_gal, first_bad;
  always @(negedge clk) begin
    if (mon_on && ram_en) begin
      if (op_n >= NOPS || ram_we !== exp_we[op_n] || ram_addr !== exp_addr[op_n] ||
          (ram_we && ram_wdata !== exp_wd[op_n])) begin
        if (err_solid + err_walk + err_gal == 0) first_bad = op_n;
        if (op_n < SOLID_OPS) err_solid++;
        else if (op_n < SOLID_OPS + WALK_OPS) err_walk++;
        else err_gal++;
      end
      op_n++;
      if (ram_we) wr_n++; else rd_n++;
    end
  end

  int cyc;
  logic [W-1:0] sig_done, sig_after_start;
  logic pass_done, pass_after_start, done_after, en_after;

  task automatic do_run(bit poke);
    op_n = 0; wr_n = 0; rd_n = 0; err_solid = 0; err_walk = 0; err_gal = 0; first_bad = -1;
    mon_on = 1;
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    sig_after_start = signature; pass_after_start = pass;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(posedge clk); #1;
      cyc++;
      if (poke && cyc == 200) start = 1'b1;
      if (poke && cyc == 201) start = 1'b0;
    end
    sig_done = signature; pass_done = pass;
    @(posedge clk); #1;
    done_after = done; en_after = ram_en;
    mon_on = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "pass in reset", pass, 0);
    chk("R1", "ram_en in reset", ram_en, 0);
    chk("R1", "ram_we in reset", ram_we, 0);
    chk("R1", "signature in reset", signature, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ram_en after release", ram_en, 0);
  endtask

  task automatic t_clean_run();
    flt_en = 0;
    do_run(1'b0);
    chk("R8", "edges to done", cyc, NOPS);
    chk("R8", "write count", wr_n, NWR);
    chk("R8", "read count", rd_n, NOPS - NWR);
    if (err_solid + err_walk + err_gal != 0) $display("first trace mismatch at access %0d", first_bad);
    chk("R4", "solid region order/data (R5)", err_solid, 0);
    chk("R6", "walking region trace", err_walk, 0);
    chk("R7", "galloping region trace", err_gal, 0);
    chk("R3", "signature at done", sig_done, GOLD);
    chk("R10", "pass at done", pass_done, 1);
    chk("R9", "done width", done_after, 0);
    chk("R9", "ram_en after done", en_after, 0);
    repeat (5) @(negedge clk);
    chk("R10", "pass held", pass, 1);
    chk("R12", "ram_en quiet while idle", ram_en, 0);
  endtask

  task automatic t_start_ignored();
    do_run(1'b1);
    chk("R2", "run length with stray start", cyc, NOPS);
    chk("R2", "trace with stray start", err_solid + err_walk + err_gal, 0);
    chk("R2", "signature with stray start", sig_done, GOLD);
  endtask

  task automatic t_rerun_clear();
    do_run(1'b0);
    chk("R3", "signature cleared at start", sig_after_start, 0);
    chk("R10", "pass dropped at start", pass_after_start, 0);
    chk("R3", "repeat signature", sig_done, GOLD);
  endtask

  task automatic t_fault();
    logic [W-1:0] e;
    flt_en = 1; flt_addr = 5; flt_bit = 3; flt_val = 1;
    e = ref_sig(1'b1, 5, 3, 1'b1);
    do_run(1'b0);
    chk("R11", "faulty signature", sig_done, e);
    chk("R11", "pass on faulty RAM", pass_done, (e == GOLD));
    chk("R11", "faulty run length", cyc, NOPS);
    flt_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    build_trace();
    t_reset();
    t_clean_run();
    t_start_ignored();
    t_rerun_clear();
    t_fault();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule